// File: doc/BRIEF.md
# Dual Four-Bit Addressable Latch

Two small storage banks, side A and side B, each hold four bits and share one 2-bit address, an active-low enable and an active-low clear. Each bank has its own single-bit data input. Together, the enable and clear lines pick one of four behaviours for both banks.

- **Wipe:** enable inactive and clear active. Every stored bit becomes zero.
- **Steer:** enable and clear both active. Each bank routes its data bit to the addressed position and zeroes the other three. This makes it a 1-of-4 demultiplexer.
- **Write:** enable active and clear inactive. Only the addressed bit of each bank takes that bank's data input, and the rest keep their values.
- **Keep:** both lines inactive. Every bit is retained.

The block is built as clocked storage. Address, controls and data are all sampled on the rising edge of one clock, and the eight outputs come straight from registers. A wrong bit therefore cannot be written by an address that changes between edges. A synchronous active-high reset empties both banks. It is typically used for serial-to-parallel loading: a bit stream is steered into successive addresses, and then the banks are left in keep mode.

Top module: `addr_latch_pair`

## Requirements
- R1: While `rst` is high at a rising clock edge, all eight outputs are 0 after that edge, whatever `enable_n` and `clear_n` are.
- R2: With `enable_n`=1 and `clear_n`=0 at an edge, `bits_a` and `bits_b` are both 0000 after that edge.
- R3: With `enable_n`=0 and `clear_n`=0 at an edge, each bank's addressed bit equals that bank's data input after the edge, and its other three bits are 0.
- R4: With `enable_n`=0 and `clear_n`=1 at an edge, each bank's addressed bit takes that bank's data input, and its other three bits keep their previous values.
- R5: With `enable_n`=1 and `clear_n`=1 at an edge, no output changes, whatever the address and data inputs are.
- R6: The address is binary with `sel[0]` as the low bit, and value k (0..3) selects output bit k: 00→bit0, 01→bit1, 10→bit2, 11→bit3.
- R7: Address and controls are common to both banks, but bank A stores only `din_a` and bank B stores only `din_b`.
- R8: Outputs change only at a rising clock edge, reflecting the inputs sampled at that edge, and stay constant between edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; all inputs are sampled on its rising edge |
| rst | input | 1 | Synchronous active-high reset; empties both banks |
| sel | input | 2 | Common bit address, sel[0] is the low bit |
| enable_n | input | 1 | Common enable, active low |
| clear_n | input | 1 | Common clear, active low |
| din_a | input | 1 | Data bit for bank A |
| din_b | input | 1 | Data bit for bank B |
| bits_a | output | 4 | Stored bits of bank A, index equals address |
| bits_b | output | 4 | Stored bits of bank B, index equals address |

## Verification
Every result appears exactly one edge after the inputs that cause it. Wipe, steer, write and keep each register once: `bits_a` and `bits_b` show the new value just after the edge that sampled the inputs. The bench drives stimulus on the falling edge, waits for the next rising edge and compares 1 ns later. For R8, it also compares right after driving, before any edge, so that a combinational leak of data or address would show up as an early change.

// File: rtl/alp_pkg.sv
package alp_pkg;

    // Operating mode decoded from the two active-low control lines
    typedef enum logic [1:0] {
        MODE_KEEP  = 2'd0,
        MODE_WRITE = 2'd1,
        MODE_STEER = 2'd2,
        MODE_WIPE  = 2'd3
    } mode_e;

endpackage

// File: rtl/alp_mode_dec.sv
module alp_mode_dec
    import alp_pkg::*;
(
    input  logic  enable_n,
    input  logic  clear_n,
    output mode_e mode
);

    always_comb begin
        unique case ({enable_n, clear_n})
            2'b10:   mode = MODE_WIPE;   // clear only acts while disabled
            2'b00:   mode = MODE_STEER;  // clear + enable: demultiplex
            2'b01:   mode = MODE_WRITE;  // enable only: addressed write
            default: mode = MODE_KEEP;   // both inactive: memory
        endcase
    end

endmodule

// File: rtl/alp_addr_dec.sv
module alp_addr_dec #(
    parameter int WIDTH  = 4,
    localparam int ADDR_W = $clog2(WIDTH)
) (
    input  logic [ADDR_W-1:0] addr,
    output logic [WIDTH-1:0]  onehot
);

    for (genvar i = 0; i < WIDTH; i++) begin : g_line
        assign onehot[i] = (addr == ADDR_W'(i));
    end

endmodule

// File: rtl/alp_bank.sv
module alp_bank
    import alp_pkg::*;
#(
    parameter int WIDTH = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  mode_e            mode,
    input  logic [WIDTH-1:0] pick,
    input  logic             din,
    output logic [WIDTH-1:0] q
);

    typedef struct packed {
        logic [WIDTH-1:0] bits;
    } bank_state_t;

    bank_state_t state_d, state_q;
    logic [WIDTH-1:0] din_fan;

    assign din_fan = {WIDTH{din}};

    always_comb begin
        state_d = state_q;
        unique case (mode)
            MODE_WIPE:  state_d.bits = '0;
            MODE_STEER: state_d.bits = pick & din_fan;
            MODE_WRITE: state_d.bits = (state_q.bits & ~pick) | (pick & din_fan);
            default:    state_d.bits = state_q.bits;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign q = state_q.bits;

endmodule

// File: rtl/addr_latch_pair.sv
module addr_latch_pair
    import alp_pkg::*;
#(
    parameter int WIDTH  = 4,
    localparam int ADDR_W = $clog2(WIDTH),
    localparam int NBANKS = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] sel,
    input  logic              enable_n,
    input  logic              clear_n,
    input  logic              din_a,
    input  logic              din_b,
    output logic [WIDTH-1:0]  bits_a,
    output logic [WIDTH-1:0]  bits_b
);

    mode_e            mode;
    logic [WIDTH-1:0] pick;
    logic             din_vec [NBANKS];
    logic [WIDTH-1:0] q_vec   [NBANKS];

    assign din_vec[0] = din_a;
    assign din_vec[1] = din_b;

    alp_mode_dec u_mode (
        .enable_n (enable_n),
        .clear_n  (clear_n),
        .mode     (mode)
    );

    alp_addr_dec #(.WIDTH(WIDTH)) u_addr (
        .addr   (sel),
        .onehot (pick)
    );

    for (genvar b = 0; b < NBANKS; b++) begin : g_bank
        alp_bank #(.WIDTH(WIDTH)) u_bank (
            .clk  (clk),
            .rst  (rst),
            .mode (mode),
            .pick (pick),
            .din  (din_vec[b]),
            .q    (q_vec[b])
        );
    end

    assign bits_a = q_vec[0];
    assign bits_b = q_vec[1];

endmodule

// File: rtl/addr_latch_pair_chk.sv
module addr_latch_pair_chk #(
    parameter int WIDTH  = 4,
    localparam int ADDR_W = $clog2(WIDTH)
) (
    input logic              clk,
    input logic              rst,
    input logic [ADDR_W-1:0] sel,
    input logic              enable_n,
    input logic              clear_n,
    input logic              din_a,
    input logic              din_b,
    input logic [WIDTH-1:0]  bits_a,
    input logic [WIDTH-1:0]  bits_b
);

    // R2: wipe empties both banks
    a_r2_wipe_zero: assert property (@(posedge clk) disable iff (rst)
        (enable_n && !clear_n) |=> (bits_a == '0 && bits_b == '0));

    // R3: steer leaves at most one bit set per bank
    a_r3_steer_onehot: assert property (@(posedge clk) disable iff (rst)
        (!enable_n && !clear_n) |=> ($onehot0(bits_a) && $onehot0(bits_b)));

    // R3 / R6: steered bit carries that bank's data
    a_r3_steer_value: assert property (@(posedge clk) disable iff (rst)
        (!enable_n && !clear_n) |=>
            (bits_a[$past(sel)] == $past(din_a) && bits_b[$past(sel)] == $past(din_b)));

    // R4 / R7: write lands the own data bit at the address
    a_r4_write_bit: assert property (@(posedge clk) disable iff (rst)
        (!enable_n && clear_n) |=>
            (bits_a[$past(sel)] == $past(din_a) && bits_b[$past(sel)] == $past(din_b)));

    // R4: write changes at most one bit per bank
    a_r4_write_one: assert property (@(posedge clk) disable iff (rst)
        (!enable_n && clear_n) |=>
            ($countones(bits_a ^ $past(bits_a)) <= 1 && $countones(bits_b ^ $past(bits_b)) <= 1));

    // R5: keep mode holds everything
    a_r5_keep_stable: assert property (@(posedge clk) disable iff (rst)
        (enable_n && clear_n) |=> ($stable(bits_a) && $stable(bits_b)));

endmodule

bind addr_latch_pair addr_latch_pair_chk #(.WIDTH(WIDTH)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .sel      (sel),
    .enable_n (enable_n),
    .clear_n  (clear_n),
    .din_a    (din_a),
    .din_b    (din_b),
    .bits_a   (bits_a),
    .bits_b   (bits_b)
);

// File: tb/addr_latch_pair_tb.sv
`timescale 1ns/1ps
module addr_latch_pair_tb;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [1:0] sel = 2'b00;
    logic       enable_n = 1'b1;
    logic       clear_n = 1'b1;
    logic       din_a = 1'b0;
    logic       din_b = 1'b0;
    logic [3:0] bits_a, bits_b;

    int n_cmp = 0;
    int n_bad = 0;
    logic [3:0] ref_a = 4'h0;
    logic [3:0] ref_b = 4'h0;

    always #2.5 clk = ~clk;

    addr_latch_pair u_dut (
        .clk(clk), .rst(rst), .sel(sel), .enable_n(enable_n), .clear_n(clear_n),
        .din_a(din_a), .din_b(din_b), .bits_a(bits_a), .bits_b(bits_b)
    );

    task automatic check(input string req, input logic [3:0] ea, input logic [3:0] eb);
        n_cmp++;
        if (bits_a !== ea || bits_b !== eb) begin
            n_bad++;
            $display("FAIL %s: bits_a=%b bits_b=%b expected %b %b", req, bits_a, bits_b, ea, eb);
        end
    endtask

    // Reference update taken from the requirement text
    task automatic model(input logic r, input logic [1:0] s, input logic en, input logic cl,
                         input logic da, input logic db);
        if (r) begin
            ref_a = 4'h0; ref_b = 4'h0;
        end else if (en && !cl) begin
            ref_a = 4'h0; ref_b = 4'h0;
        end else if (!en && !cl) begin
            ref_a = 4'h0; ref_b = 4'h0;
            ref_a[s] = da; ref_b[s] = db;
        end else if (!en && cl) begin
            ref_a[s] = da; ref_b[s] = db;
        end
    endtask

    // Drive on falling edge, let one rising edge sample, look 1 ns after it
    task automatic step(input logic r, input logic [1:0] s, input logic en, input logic cl,
                        input logic da, input logic db);
        @(negedge clk);
        rst = r; sel = s; enable_n = en; clear_n = cl; din_a = da; din_b = db;
        @(posedge clk);
        #1;
        model(r, s, en, cl, da, db);
    endtask

    task automatic t_reset();
        step(1'b0, 2'b00, 1'b0, 1'b1, 1'b1, 1'b1);     // write a bit first
        step(1'b1, 2'b01, 1'b0, 1'b1, 1'b1, 1'b1);     // reset wins over a write
        check("R1 reset overrides write", 4'h0, 4'h0);
    endtask

    task automatic t_write();
        step(1'b0, 2'b00, 1'b0, 1'b1, 1'b1, 1'b0);
        check("R4 write bit0", ref_a, ref_b);
        step(1'b0, 2'b10, 1'b0, 1'b1, 1'b1, 1'b1);
        check("R4 write bit2 keeps bit0", 4'b0101, 4'b0100);
        step(1'b0, 2'b00, 1'b0, 1'b1, 1'b0, 1'b1);
        check("R4 overwrite bit0", 4'b0100, 4'b0101);
    endtask

    task automatic t_map();
        for (int k = 0; k < 4; k++) begin
            step(1'b0, 2'(k), 1'b1, 1'b0, 1'b0, 1'b0);  // wipe
            step(1'b0, 2'(k), 1'b0, 1'b1, 1'b1, 1'b0);  // write A only
            check("R6 address selects bit k", 4'(1 << k), 4'h0);
        end
    endtask

    task automatic t_banks();
        step(1'b0, 2'b11, 1'b0, 1'b1, 1'b0, 1'b1);
        step(1'b0, 2'b01, 1'b0, 1'b1, 1'b1, 1'b0);
        check("R7 separate data per bank", ref_a, ref_b);
    endtask

    task automatic t_keep();
        logic [3:0] ha, hb;
        ha = ref_a; hb = ref_b;
        for (int k = 0; k < 4; k++) begin
            step(1'b0, 2'(k), 1'b1, 1'b1, k[0], ~k[0]);
            check("R5 keep ignores addr/data", ha, hb);
        end
    endtask

    task automatic t_steer();
        step(1'b0, 2'b00, 1'b0, 1'b1, 1'b1, 1'b1);      // preload bit0
        step(1'b0, 2'b10, 1'b0, 1'b0, 1'b1, 1'b0);
        check("R3 steer bit2 zeroes others", 4'b0100, 4'b0000);
        step(1'b0, 2'b11, 1'b0, 1'b0, 1'b0, 1'b1);
        check("R3 steer bit3", 4'b0000, 4'b1000);
    endtask

    task automatic t_wipe();
        step(1'b0, 2'b01, 1'b0, 1'b1, 1'b1, 1'b1);
        step(1'b0, 2'b10, 1'b0, 1'b1, 1'b1, 1'b1);
        step(1'b0, 2'b11, 1'b1, 1'b0, 1'b1, 1'b1);
        check("R2 wipe clears all eight", 4'h0, 4'h0);
    endtask

    task automatic t_timing();
        logic [3:0] ha, hb;
        step(1'b0, 2'b00, 1'b1, 1'b0, 1'b0, 1'b0);      // all zero
        ha = ref_a; hb = ref_b;
        @(negedge clk);
        sel = 2'b01; enable_n = 1'b0; clear_n = 1'b1; din_a = 1'b1; din_b = 1'b1;
        #1;
        check("R8 no change before edge", ha, hb);
        @(posedge clk);
        #1;
        model(1'b0, 2'b01, 1'b0, 1'b1, 1'b1, 1'b1);
        check("R8 change after edge", 4'b0010, 4'b0010);
        #2;
        check("R8 stable between edges", 4'b0010, 4'b0010);
    endtask

    initial begin
        #200_000;
        n_bad++;
        $display("FAIL watchdog: run did not finish, actual hung expected done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        check("R1 reset state", 4'h0, 4'h0);
        t_write();
        t_reset();
        t_map();
        t_banks();
        t_keep();
        t_steer();
        t_wipe();
        t_timing();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule